// File: doc/BRIEF.md
# Disk Byte Holding Register Handshake

This block sits between the byte-wide side of a serial disk data path and an 8-bit holding register that a host reads and writes. When the drive is being read, the deserializer presents each finished byte with a one-cycle strobe. The block copies that byte into the holding register and raises a data request so the host knows a byte is waiting. The host read then clears the request. When the drive is being written, the serializer pulses a strobe each time it needs its next byte. The block hands over the held byte and raises the request so the host supplies the following one. The host write clears the request.

The block never stalls the disk. On a read, a byte that arrives before the host has taken the previous one replaces it, and a sticky lost-data flag is set. On a write, if the host has not refilled the register in time, the serializer gets the fill byte (all zeros) and the same flag is set. The flag is cleared only by the start of a new command or by reset. A status byte carries the request and the flag at fixed bit positions for a status register nearby.

Top module: `dskbuf_xfer`

## Requirements
- R1: In read mode (`mode_wr`=0), a `ser_rdy` pulse loads `ser_rbyte` into the holding register, which appears on `host_rdata` after the next edge, and `drq` is high from that edge on.
- R2: In read mode, a `host_rd` pulse clears `drq` at the next edge, unless `ser_rdy` is high in the same cycle. In that case the host sees the old byte during that cycle, `drq` stays high and the new byte is held.
- R3: In read mode, a `ser_rdy` pulse while `drq` is high and `host_rd` is low sets `lost`, and the new byte still replaces the held one.
- R4: In write mode (`mode_wr`=1), a `ser_need` pulse while `drq` is low puts the held byte on `ser_wbyte` at the next edge and sets `drq`.
- R5: In write mode, a `host_wr` pulse stores `host_wdata` in the holding register and clears `drq` at the next edge, unless `ser_need` is high in the same cycle.
- R6: In write mode, a `ser_need` pulse while `drq` is high and `host_wr` is low drives `ser_wbyte` to 8'h00 and sets `lost`, and `drq` stays high.
- R7: In write mode, when `ser_need` and `host_wr` are high in the same cycle, `ser_wbyte` takes `host_wdata`, `lost` is not set, and `drq` is high afterwards.
- R8: `lost` stays set until a `cmd_start` pulse. `cmd_start` clears `lost`, sets `drq` to the value of `mode_wr`, and overrides every other strobe in the same cycle, so `ser_wbyte` and the holding register keep their values.
- R9: After reset, `drq`, `lost`, `ser_wbyte`, `host_rdata` and `status` are all zero.
- R10: The `status` byte carries `drq` at bit 1 and `lost` at bit 2. Every other bit is 0.
- R11: The strobes of the other mode have no effect. `host_wr` and `ser_need` are ignored in read mode, and `host_rd` and `ser_rdy` are ignored in write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | 1 = disk write transfer, 0 = disk read transfer |
| cmd_start | input | 1 | One-cycle pulse when a new command begins |
| host_rd | input | 1 | Host read strobe for the holding register |
| host_wr | input | 1 | Host write strobe for the holding register |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Current holding register contents |
| ser_rdy | input | 1 | Deserializer has a finished byte |
| ser_rbyte | input | 8 | Byte from the deserializer |
| ser_need | input | 1 | Serializer needs its next byte |
| ser_wbyte | output | 8 | Byte handed to the serializer |
| drq | output | 1 | Data request to the host |
| lost | output | 1 | Sticky lost-data flag |
| status | output | 8 | Status byte: bit 1 `drq`, bit 2 `lost` |

## Verification
The two functions that can fall in the same cycle are the disk-side strobe and the host strobe. In read mode this is `ser_rdy` together with `host_rd`. In write mode it is `ser_need` together with `host_wr`. The bench raises both strobes in one cycle right after a `cmd_start` has cleared `lost`. For a read, it judges the outcome by the old byte on `host_rdata` during the cycle, then the new byte, `drq` still high and `lost` still low. For a write, it expects the host byte on `ser_wbyte` instead of zeros, with `lost` low. A third collision, `cmd_start` arriving with `ser_need` during an underrun, is judged by `lost` staying clear and `ser_wbyte` keeping its previous value.

// File: rtl/dskbuf_pkg.sv
package dskbuf_pkg;
   // Decoded transfer events for one clock cycle
   typedef struct packed {
      logic rd_load;   // disk byte arrived (read mode)
      logic rd_take;   // host read holding register (read mode)
      logic wr_fill;   // host wrote holding register (write mode)
      logic wr_pull;   // serializer wants a byte (write mode)
   } xfer_ev_t;

   localparam int unsigned DEF_DATA_W   = 8;
   localparam int unsigned DEF_STAT_W   = 8;
   localparam int unsigned DEF_DRQ_POS  = 1;
   localparam int unsigned DEF_LOST_POS = 2;
endpackage

// File: rtl/dskbuf_req.sv
module dskbuf_req
   import dskbuf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cmd_start,
   input  logic     mode_wr,
   input  xfer_ev_t ev,
   output logic     drq,
   output logic     lost
);
   logic drq_nx;
   logic lost_set;

   always_comb begin
      drq_nx = drq;
      if (cmd_start)         drq_nx = mode_wr;
      else if (ev.rd_load)   drq_nx = 1'b1;
      else if (ev.rd_take)   drq_nx = 1'b0;
      else if (ev.wr_pull)   drq_nx = 1'b1;
      else if (ev.wr_fill)   drq_nx = 1'b0;
   end

   assign lost_set = !cmd_start &&
                     ((ev.rd_load && drq && !ev.rd_take) ||
                      (ev.wr_pull && drq && !ev.wr_fill));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drq  <= 1'b0;
         lost <= 1'b0;
      end else begin
         drq <= drq_nx;
         if (cmd_start)     lost <= 1'b0;
         else if (lost_set) lost <= 1'b1;
      end
   end

   AST_RD_LOAD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.rd_load && !cmd_start) |=> drq);                          // R1
   AST_RD_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.rd_take && !ev.rd_load && !cmd_start) |=> !drq);          // R2
   AST_RD_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.rd_load && drq && !ev.rd_take && !cmd_start) |=> lost);   // R3
   AST_WR_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.wr_fill && !ev.wr_pull && !cmd_start) |=> !drq);         // R5
   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lost && !cmd_start) |=> lost);                               // R8
   AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> (!lost && (drq == $past(mode_wr))));             // R8
endmodule

// File: rtl/dskbuf_hold.sv
module dskbuf_hold
   import dskbuf_pkg::*;
#(
   parameter int unsigned           DATA_W    = DEF_DATA_W,
   parameter logic [DATA_W-1:0]     FILL_BYTE = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  xfer_ev_t          ev,
   input  logic              drq,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] ser_rbyte,
   output logic [DATA_W-1:0] hold_q,
   output logic [DATA_W-1:0] ser_wbyte
);
   logic [DATA_W-1:0] out_nx;

   always_comb begin
      if (ev.wr_fill)   out_nx = host_wdata;   // same-cycle host write wins
      else if (!drq)    out_nx = hold_q;       // register full
      else              out_nx = FILL_BYTE;    // underrun
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q    <= '0;
         ser_wbyte <= '0;
      end else begin
         if (ev.rd_load)      hold_q <= ser_rbyte;
         else if (ev.wr_fill) hold_q <= host_wdata;
         if (ev.wr_pull)      ser_wbyte <= out_nx;
      end
   end

   AST_UNDERRUN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.wr_pull && drq && !ev.wr_fill) |=> (ser_wbyte == FILL_BYTE)); // R6
   AST_COLLIDE_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.wr_pull && ev.wr_fill) |=> (ser_wbyte == $past(host_wdata)));  // R7
   AST_PULL_ONLY_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      !ev.wr_pull |=> $stable(ser_wbyte));                               // R11
endmodule

// File: rtl/dskbuf_stat.sv
module dskbuf_stat #(
   parameter int unsigned STAT_W   = 8,
   parameter int unsigned DRQ_POS  = 1,
   parameter int unsigned LOST_POS = 2
)(
   input  logic              drq,
   input  logic              lost,
   output logic [STAT_W-1:0] stat_o
);
   if (DRQ_POS >= STAT_W || LOST_POS >= STAT_W || DRQ_POS == LOST_POS) begin : g_bad_pos
      $error("dskbuf_stat: status bit positions invalid");
   end

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (i == DRQ_POS) begin : g_drq
         assign stat_o[i] = drq;
      end else if (i == LOST_POS) begin : g_lost
         assign stat_o[i] = lost;
      end else begin : g_zero
         assign stat_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/dskbuf_xfer.sv
module dskbuf_xfer
   import dskbuf_pkg::*;
#(
   parameter int unsigned DATA_W   = DEF_DATA_W,
   parameter int unsigned STAT_W   = DEF_STAT_W,
   parameter int unsigned DRQ_POS  = DEF_DRQ_POS,
   parameter int unsigned LOST_POS = DEF_LOST_POS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              cmd_start,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              ser_rdy,
   input  logic [DATA_W-1:0] ser_rbyte,
   input  logic              ser_need,
   output logic [DATA_W-1:0] ser_wbyte,
   output logic              drq,
   output logic              lost,
   output logic [STAT_W-1:0] status
);
   if (DATA_W < 1) begin : g_bad_w
      $error("dskbuf_xfer: DATA_W must be at least 1");
   end

   xfer_ev_t ev;

   // cmd_start masks every transfer event in its cycle
   always_comb begin
      ev.rd_load = !cmd_start && !mode_wr && ser_rdy;
      ev.rd_take = !cmd_start && !mode_wr && host_rd;
      ev.wr_fill = !cmd_start &&  mode_wr && host_wr;
      ev.wr_pull = !cmd_start &&  mode_wr && ser_need;
   end

   dskbuf_req u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .mode_wr   (mode_wr),
      .ev        (ev),
      .drq       (drq),
      .lost      (lost)
   );

   dskbuf_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev         (ev),
      .drq        (drq),
      .host_wdata (host_wdata),
      .ser_rbyte  (ser_rbyte),
      .hold_q     (host_rdata),
      .ser_wbyte  (ser_wbyte)
   );

   dskbuf_stat #(.STAT_W(STAT_W), .DRQ_POS(DRQ_POS), .LOST_POS(LOST_POS)) u_stat (
      .drq    (drq),
      .lost   (lost),
      .stat_o (status)
   );

   AST_WR_PULL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && ser_need && !cmd_start) |=> drq);                 // R4
   AST_OTHER_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !host_wr && !cmd_start) |=> $stable(host_rdata)); // R11
endmodule

// File: tb/dskbuf_xfer_test.sv
module dskbuf_xfer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0, cmd_start = 1'b0;
   logic       host_rd = 1'b0, host_wr = 1'b0, ser_rdy = 1'b0, ser_need = 1'b0;
   logic [7:0] host_wdata = '0, ser_rbyte = '0;
   logic [7:0] host_rdata, ser_wbyte, status;
   logic       drq, lost;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   dskbuf_xfer uut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .cmd_start(cmd_start),
      .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .ser_rdy(ser_rdy), .ser_rbyte(ser_rbyte),
      .ser_need(ser_need), .ser_wbyte(ser_wbyte), .drq(drq), .lost(lost),
      .status(status)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // apply current inputs at the next edge, sample 2 ns later, drop strobes
   task automatic step();
      @(posedge clk);
      #2;
      cmd_start = 0; host_rd = 0; host_wr = 0; ser_rdy = 0; ser_need = 0;
   endtask

   task automatic t_reset();
      chk("R9", "drq", {7'b0, drq}, 8'h00);
      chk("R9", "lost", {7'b0, lost}, 8'h00);
      chk("R9", "ser_wbyte", ser_wbyte, 8'h00);
      chk("R9", "host_rdata", host_rdata, 8'h00);
      chk("R9", "status", status, 8'h00);
   endtask

   task automatic t_read_basic();
      mode_wr = 0; cmd_start = 1; step();
      chk("R8", "drq after read cmd", {7'b0, drq}, 8'h00);
      ser_rdy = 1; ser_rbyte = 8'hA5; step();
      chk("R1", "drq", {7'b0, drq}, 8'h01);
      chk("R1", "host_rdata", host_rdata, 8'hA5);
      chk("R10", "status", status, 8'h02);
      host_rd = 1; step();
      chk("R2", "drq after read", {7'b0, drq}, 8'h00);
      chk("R2", "lost", {7'b0, lost}, 8'h00);
   endtask

   task automatic t_read_overrun();
      ser_rdy = 1; ser_rbyte = 8'h3C; step();
      ser_rdy = 1; ser_rbyte = 8'h5A; step();
      chk("R3", "lost", {7'b0, lost}, 8'h01);
      chk("R3", "host_rdata", host_rdata, 8'h5A);
      chk("R10", "status", status, 8'h06);
      host_rd = 1; step();
      chk("R8", "lost sticky", {7'b0, lost}, 8'h01);
      cmd_start = 1; ser_rdy = 1; ser_rbyte = 8'hEE; step();
      chk("R8", "lost cleared", {7'b0, lost}, 8'h00);
      chk("R8", "ser_rdy masked", host_rdata, 8'h5A);
      chk("R8", "drq read cmd", {7'b0, drq}, 8'h00);
   endtask

   task automatic t_read_collide();
      ser_rdy = 1; ser_rbyte = 8'h11; step();
      ser_rdy = 1; ser_rbyte = 8'h22; host_rd = 1;
      #1 chk("R2", "old byte seen", host_rdata, 8'h11);
      step();
      chk("R2", "drq stays", {7'b0, drq}, 8'h01);
      chk("R2", "new byte", host_rdata, 8'h22);
      chk("R3", "no lost on collide", {7'b0, lost}, 8'h00);
   endtask

   task automatic t_read_ignores();
      host_wr = 1; host_wdata = 8'hFF; ser_need = 1; step();
      chk("R11", "host_wr ignored", host_rdata, 8'h22);
      chk("R11", "drq unchanged", {7'b0, drq}, 8'h01);
      chk("R11", "ser_wbyte unchanged", ser_wbyte, 8'h00);
   endtask

   task automatic t_write();
      mode_wr = 1; cmd_start = 1; step();
      chk("R8", "drq write cmd", {7'b0, drq}, 8'h01);
      host_wr = 1; host_wdata = 8'h81; step();
      chk("R5", "drq cleared", {7'b0, drq}, 8'h00);
      chk("R5", "held", host_rdata, 8'h81);
      ser_need = 1; step();
      chk("R4", "ser_wbyte", ser_wbyte, 8'h81);
      chk("R4", "drq", {7'b0, drq}, 8'h01);
      chk("R4", "lost", {7'b0, lost}, 8'h00);
      ser_need = 1; step();
      chk("R6", "zero byte", ser_wbyte, 8'h00);
      chk("R6", "lost", {7'b0, lost}, 8'h01);
      chk("R6", "drq", {7'b0, drq}, 8'h01);
      host_wr = 1; host_wdata = 8'h42; step();
      chk("R8", "lost sticky in write", {7'b0, lost}, 8'h01);
      ser_need = 1; step();
      chk("R4", "ser_wbyte 2", ser_wbyte, 8'h42);
   endtask

   task automatic t_write_collide();
      cmd_start = 1; step();
      ser_need = 1; host_wr = 1; host_wdata = 8'h99; step();
      chk("R7", "host byte", ser_wbyte, 8'h99);
      chk("R7", "lost", {7'b0, lost}, 8'h00);
      chk("R7", "drq", {7'b0, drq}, 8'h01);
      ser_need = 1; step();
      chk("R6", "underrun lost", {7'b0, lost}, 8'h01);
      cmd_start = 1; ser_need = 1; step();
      chk("R8", "cmd wins lost", {7'b0, lost}, 8'h00);
      chk("R8", "cmd wins wbyte", ser_wbyte, 8'h00);
      host_rd = 1; ser_rdy = 1; ser_rbyte = 8'h77; step();
      chk("R11", "ser_rdy ignored", host_rdata, 8'h99);
      chk("R11", "drq", {7'b0, drq}, 8'h01);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      t_reset();
      t_read_basic();
      t_read_overrun();
      t_read_collide();
      t_read_ignores();
      t_write();
      t_write_collide();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule